// File: doc/BRIEF.md
# Descriptor Write-Commit Buffer

This block is the entry port for descriptors in a scatter-gather DMA dispatcher. A host uses a plain 32-bit word-addressed write port to fill eight staging registers that together make up one 256-bit descriptor. Nothing moves into the queue while the host is still writing. The descriptor enters a first-in first-out queue as a single entry only when the host writes the control word with its go flag set. Because of this, a downstream read/write engine never sees a descriptor that is only partly written.

The head of the queue goes to the engine through a valid/ready handshake. Next to the raw 256-bit entry, the block decodes the head entry's burst, sequence, stride and channel fields for the engine. A burst field of zero is reported as the maximum burst length. The queue reports empty, full and a packed fill level to a status block. A go write that arrives while the queue is full is discarded and sets a sticky overflow flag.

Top module: `desc_commit_buf`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` in staging word `wr_addr`. The words are: 0 read address low, 1 write address low, 2 length, 3 burst/sequence, 4 stride, 5 read address high, 6 write address high, 7 control. Word k occupies bits 32k+31 down to 32k of a queued entry.
- R2: A write to word 7 with bit 31 (go) set pushes one entry. The entry holds staged words 0..6 and the control value being written. When the queue was empty, the entry appears on `desc_data` with `desc_valid` high in the next cycle.
- R3: A write to word 7 with bit 31 clear updates the staged control word and pushes nothing.
- R4: Entries leave in the order they were committed. One entry is removed on each cycle in which `desc_valid` and `desc_ready` are both high.
- R5: `buf_empty` is high exactly when the queue holds no entry. `buf_full` is high exactly when it holds DEPTH entries.
- R6: `fill_level` carries the entry count in both bits 31:16 and bits 15:0. A push and a pop in the same cycle leave the count unchanged.
- R7: A go write in a cycle where `buf_full` is high is dropped, even if a pop happens in that cycle. The drop sets `overflow`, which stays high until reset. Queued entries and staging words 0..6 are unaffected.
- R8: While `desc_valid` is high and `desc_ready` is low, `desc_valid` stays high and `desc_data` does not change.
- R9: Word 3 of the head entry holds the read burst in bits 23:16 and the write burst in bits 31:24. The block reports each on `head_rd_burst` and `head_wr_burst`, with a value of 0 reported as BURST_MAX (default 256).
- R10: `head_seq` is bits 15:0 of word 3. `head_rd_stride` is bits 15:0 of word 4 and `head_wr_stride` is bits 31:16 of word 4. `head_channel` is bits 7:0 of word 7.
- R11: After reset the queue is empty (`buf_empty` high, `buf_full` and `desc_valid` low), `fill_level` is 0 and `overflow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Staging word index |
| wr_data | input | 32 | Host write data |
| desc_valid | output | 1 | Head entry available to the engine |
| desc_ready | input | 1 | Engine accepts the head entry |
| desc_data | output | 256 | Head entry, word k in bits 32k+31:32k |
| buf_empty | output | 1 | Queue holds no entry |
| buf_full | output | 1 | Queue holds DEPTH entries |
| fill_level | output | 32 | Entry count in both halves |
| overflow | output | 1 | Sticky: a go write was dropped |
| head_rd_burst | output | 9 | Read burst of the head entry, 0 mapped to maximum |
| head_wr_burst | output | 9 | Write burst of the head entry, 0 mapped to maximum |
| head_seq | output | 16 | Sequence number of the head entry |
| head_rd_stride | output | 16 | Read stride of the head entry |
| head_wr_stride | output | 16 | Write stride of the head entry |
| head_channel | output | 8 | Channel of the head entry |

## Verification
The hardest situation to reach is a go write that arrives while the queue is full. A harder variant is a go write that arrives while the queue is full and the engine is taking an entry in that same cycle, because the drop has to win over the freed slot. The stimulus holds `desc_ready` low while it commits DEPTH descriptors. It then commits once more while still stalled, and a second time with `desc_ready` raised in the same cycle. After each of these, it drains the queue with `desc_ready` toggling and commits again without rewriting words 0..6. This shows that the staging words survived the drop.

// File: rtl/desc_commit_pkg.sv
package desc_commit_pkg;

    localparam int WORD_W  = 32;
    localparam int N_WORDS = 8;
    localparam int DESC_W  = WORD_W * N_WORDS;
    localparam int GO_BIT  = 31;

    typedef enum logic [2:0] {
        W_RD_LO     = 3'd0,
        W_WR_LO     = 3'd1,
        W_LEN       = 3'd2,
        W_BURST_SEQ = 3'd3,
        W_STRIDE    = 3'd4,
        W_RD_HI     = 3'd5,
        W_WR_HI     = 3'd6,
        W_CTRL      = 3'd7
    } word_sel_e;

    typedef struct packed {
        logic       go;
        logic [5:0] rsvd;
        logic       early_done;
        logic [7:0] err_irq_mask;
        logic       early_irq_en;
        logic       cmpl_irq_en;
        logic       end_on_len;
        logic       end_on_eop;
        logic       park_wr;
        logic       park_rd;
        logic       gen_eop;
        logic       gen_sop;
        logic [7:0] channel;
    } ctrl_word_t;

    typedef struct packed {
        logic [7:0]  wr_burst;
        logic [7:0]  rd_burst;
        logic [15:0] seq;
    } burst_seq_t;

    typedef struct packed {
        logic [15:0] wr;
        logic [15:0] rd;
    } stride_t;

    typedef struct packed {
        ctrl_word_t  ctrl;
        logic [31:0] wr_hi;
        logic [31:0] rd_hi;
        stride_t     stride;
        burst_seq_t  burst_seq;
        logic [31:0] len;
        logic [31:0] wr_lo;
        logic [31:0] rd_lo;
    } desc_t;

endpackage

// File: rtl/desc_stage.sv
module desc_stage
    import desc_commit_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [2:0]                        wr_addr,
    input  logic [WORD_W-1:0]                 wr_data,
    output logic                              commit_req,
    output logic [N_WORDS-1:0][WORD_W-1:0]    commit_entry
);

    typedef struct packed {
        logic [N_WORDS-1:0][WORD_W-1:0] words;
    } stage_st_t;

    stage_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        commit_entry = st_q.words;
        commit_entry[W_CTRL] = wr_data;
        commit_req   = wr_en && (wr_addr == 3'(W_CTRL)) && wr_data[GO_BIT];
        if (wr_en) begin
            st_d.words[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a written word holds its value in the next cycle
    assert_word_captured_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.words[$past(wr_addr)] == $past(wr_data));

    // R7: words 0..6 are only changed by a host write
    assert_stage_intact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> st_q.words == $past(st_q.words));

endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_req,
    input  logic [W-1:0]                  push_data,
    input  logic                          pop_ready,
    output logic                          out_valid,
    output logic [W-1:0]                  out_data,
    output logic                          empty,
    output logic                          full,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          drop
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push_req && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop_ready && (st_q.cnt != '0);
        if (push_ok) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp           = ptr_next(st_q.wp);
        end
        if (pop_ok) begin
            st_d.rp = ptr_next(st_q.rp);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = (st_q.cnt != '0);
    assign out_data  = st_q.mem[st_q.rp];
    assign empty     = (st_q.cnt == '0);
    assign full      = (st_q.cnt == CNT_W'(DEPTH));
    assign count     = st_q.cnt;
    assign drop      = push_req && full;

    // R5: the two flags never coexist
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R6: a push with no pop raises the count by one
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !full && !(pop_ready && !empty)) |=> count == $past(count) + 1'b1);

    // R8: a stalled head is held
    assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/desc_head_view.sv
module desc_head_view
    import desc_commit_pkg::*;
#(
    parameter int BURST_MAX = 256,
    parameter int BW        = $clog2(BURST_MAX + 1)
) (
    input  burst_seq_t       bs,
    input  stride_t          stride,
    input  logic [7:0]       channel_in,
    output logic [BW-1:0]    rd_burst,
    output logic [BW-1:0]    wr_burst,
    output logic [15:0]      seq,
    output logic [15:0]      rd_stride,
    output logic [15:0]      wr_stride,
    output logic [7:0]       channel
);

    localparam int N_LANES = 2;

    logic [N_LANES-1:0][7:0]    raw;
    logic [N_LANES-1:0][BW-1:0] eff;

    assign raw[0] = bs.rd_burst;
    assign raw[1] = bs.wr_burst;

    for (genvar g = 0; g < N_LANES; g++) begin : g_burst
        assign eff[g] = (raw[g] == 8'd0) ? BW'(BURST_MAX) : BW'(raw[g]);
    end

    assign rd_burst  = eff[0];
    assign wr_burst  = eff[1];
    assign seq       = bs.seq;
    assign rd_stride = stride.rd;
    assign wr_stride = stride.wr;
    assign channel   = channel_in;

endmodule

// File: rtl/desc_commit_buf.sv
module desc_commit_buf
    import desc_commit_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int BURST_MAX = 256
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [2:0]                         wr_addr,
    input  logic [31:0]                        wr_data,
    output logic                               desc_valid,
    input  logic                               desc_ready,
    output logic [255:0]                       desc_data,
    output logic                               buf_empty,
    output logic                               buf_full,
    output logic [31:0]                        fill_level,
    output logic                               overflow,
    output logic [$clog2(BURST_MAX+1)-1:0]     head_rd_burst,
    output logic [$clog2(BURST_MAX+1)-1:0]     head_wr_burst,
    output logic [15:0]                        head_seq,
    output logic [15:0]                        head_rd_stride,
    output logic [15:0]                        head_wr_stride,
    output logic [7:0]                         head_channel
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BW    = $clog2(BURST_MAX + 1);

    typedef struct packed {
        logic ovf;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                           commit_req;
    logic [N_WORDS-1:0][WORD_W-1:0] commit_entry;
    logic                           fifo_drop;
    logic [CNT_W-1:0]               cnt;
    logic [DESC_W-1:0]              head_raw;
    desc_t                          head;

    desc_stage u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .commit_req   (commit_req),
        .commit_entry (commit_entry)
    );

    desc_fifo #(.DEPTH(DEPTH), .W(DESC_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (commit_req),
        .push_data (commit_entry),
        .pop_ready (desc_ready),
        .out_valid (desc_valid),
        .out_data  (head_raw),
        .empty     (buf_empty),
        .full      (buf_full),
        .count     (cnt),
        .drop      (fifo_drop)
    );

    assign head      = desc_t'(head_raw);
    assign desc_data = head_raw;

    desc_head_view #(.BURST_MAX(BURST_MAX), .BW(BW)) u_view (
        .bs         (head.burst_seq),
        .stride     (head.stride),
        .channel_in (head.ctrl.channel),
        .rd_burst   (head_rd_burst),
        .wr_burst   (head_wr_burst),
        .seq        (head_seq),
        .rd_stride  (head_rd_stride),
        .wr_stride  (head_wr_stride),
        .channel    (head_channel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = st_q.ovf | fifo_drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overflow   = st_q.ovf;
    assign fill_level = {16'(cnt), 16'(cnt)};

    // R7: a go write against a full queue raises the sticky flag
    assert_go_full_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'(W_CTRL) && wr_data[GO_BIT] && buf_full) |=> overflow);

    // R7: the flag stays up once raised
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R3: a control write without go leaves the level untouched
    assert_no_push_without_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'(W_CTRL) && !wr_data[GO_BIT] && !(desc_valid && desc_ready))
        |=> fill_level == $past(fill_level));

endmodule

// File: tb/tb_desc_commit_buf.sv
module tb_desc_commit_buf;

    localparam int DEPTH = 8;
    localparam int BMAX  = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wen = 1'b0;
    logic [2:0]   waddr = '0;
    logic [31:0]  wdata = '0;
    logic         rdy = 1'b0;
    logic         desc_valid, buf_empty, buf_full, overflow;
    logic [255:0] desc_data;
    logic [31:0]  fill_level;
    logic [8:0]   head_rd_burst, head_wr_burst;
    logic [15:0]  head_seq, head_rd_stride, head_wr_stride;
    logic [7:0]   head_channel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [255:0] mq[$];
    logic [31:0]  stg[8];
    bit           movf = 1'b0;

    always #4 clk = ~clk;

    desc_commit_buf #(.DEPTH(DEPTH), .BURST_MAX(BMAX)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wen), .wr_addr(waddr), .wr_data(wdata),
        .desc_valid(desc_valid), .desc_ready(rdy), .desc_data(desc_data),
        .buf_empty(buf_empty), .buf_full(buf_full), .fill_level(fill_level),
        .overflow(overflow), .head_rd_burst(head_rd_burst), .head_wr_burst(head_wr_burst),
        .head_seq(head_seq), .head_rd_stride(head_rd_stride),
        .head_wr_stride(head_wr_stride), .head_channel(head_channel)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] eff_burst(input logic [7:0] b);
        return (b == 8'd0) ? 9'(BMAX) : {1'b0, b};
    endfunction

    task automatic compare_all();
        int sz = mq.size();
        chk(desc_valid == (sz > 0), "R4 valid", 256'(desc_valid), 256'(sz > 0));
        chk(buf_empty == (sz == 0), "R5 empty", 256'(buf_empty), 256'(sz == 0));
        chk(buf_full == (sz == DEPTH), "R5 full", 256'(buf_full), 256'(sz == DEPTH));
        chk(fill_level == {16'(sz), 16'(sz)}, "R6 fill", 256'(fill_level), 256'({16'(sz), 16'(sz)}));
        chk(overflow == movf, "R7 overflow", 256'(overflow), 256'(movf));
        if (sz > 0) begin
            logic [31:0] w3 = mq[0][96 +: 32];
            logic [31:0] w4 = mq[0][128 +: 32];
            chk(desc_data == mq[0], "R4 head data", desc_data, mq[0]);
            chk(head_rd_burst == eff_burst(w3[23:16]), "R9 rd burst", 256'(head_rd_burst), 256'(eff_burst(w3[23:16])));
            chk(head_wr_burst == eff_burst(w3[31:24]), "R9 wr burst", 256'(head_wr_burst), 256'(eff_burst(w3[31:24])));
            chk(head_seq == w3[15:0], "R10 seq", 256'(head_seq), 256'(w3[15:0]));
            chk(head_rd_stride == w4[15:0], "R10 rd stride", 256'(head_rd_stride), 256'(w4[15:0]));
            chk(head_wr_stride == w4[31:16], "R10 wr stride", 256'(head_wr_stride), 256'(w4[31:16]));
            chk(head_channel == mq[0][224 +: 8], "R10 channel", 256'(head_channel), 256'(mq[0][224 +: 8]));
        end
    endtask

    task automatic tick();
        bit do_pop, go, was_full;
        logic [255:0] ent;
        @(posedge clk);
        do_pop   = (mq.size() > 0) && rdy;
        go       = wen && (waddr == 3'd7) && wdata[31];
        was_full = (mq.size() == DEPTH);
        for (int k = 0; k < 8; k++) ent[32*k +: 32] = (k == 7) ? wdata : stg[k];
        if (wen) stg[waddr] = wdata;
        if (do_pop) void'(mq.pop_front());
        if (go) begin
            if (was_full) movf = 1'b1;
            else          mq.push_back(ent);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wen = 1'b1; waddr = a; wdata = d;
        tick();
        wen = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [255:0] held;
        for (int k = 0; k < 8; k++) stg[k] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(buf_empty && !buf_full && !desc_valid, "R11 flags", 256'({buf_empty, buf_full, desc_valid}), 256'(3'b100));
        chk(fill_level == 32'd0 && !overflow, "R11 fill/overflow", 256'({fill_level, overflow}), 256'(0));
        rst_n = 1'b1;
        idle(1);

        // R1: load staging words with distinct patterns
        wr(3'd0, 32'hA000_0010);
        wr(3'd1, 32'hB000_0020);
        wr(3'd2, 32'h0000_1000);
        wr(3'd3, 32'h0000_0005);   // both bursts 0 -> maximum
        wr(3'd4, 32'h0001_0001);
        wr(3'd5, 32'h0000_00A1);
        wr(3'd6, 32'h0000_00B1);
        // R3: control without go pushes nothing
        wr(3'd7, 32'h0000_3105);
        chk(buf_empty && fill_level == 0, "R3 no push", 256'(fill_level), 256'(0));
        // R2: go commits
        wr(3'd7, 32'h8000_3105);
        chk(desc_valid, "R2 valid after go", 256'(desc_valid), 256'(1));
        for (int k = 0; k < 8; k++)
            chk(desc_data[32*k +: 32] == stg[k], "R1 word layout", 256'(desc_data[32*k +: 32]), 256'(stg[k]));
        chk(head_rd_burst == 9'd256 && head_wr_burst == 9'd256, "R9 zero burst", 256'({head_rd_burst, head_wr_burst}), 256'({9'd256, 9'd256}));
        // R8: stalled head stays put
        held = desc_data;
        idle(3);
        chk(desc_valid && desc_data == held, "R8 stall hold", desc_data, held);

        // fill to full with varied burst/stride words
        for (int i = 1; i < DEPTH; i++) begin
            wr(3'd3, {8'(i), 8'(i * 3), 16'(i + 100)});
            wr(3'd4, {16'(i * 2), 16'(i)});
            wr(3'd7, 32'h8000_0000 | 32'(i));
        end
        chk(buf_full, "R5 full after DEPTH commits", 256'(buf_full), 256'(1));
        // R7: go while full dropped
        wr(3'd7, 32'h8000_00FF);
        chk(overflow && fill_level[15:0] == 16'(DEPTH), "R7 drop", 256'({overflow, fill_level}), 256'({1'b1, 16'(DEPTH), 16'(DEPTH)}));
        // R7: go while full with concurrent pop is still dropped
        rdy = 1'b1;
        wr(3'd7, 32'h8000_00EE);
        chk(fill_level[15:0] == 16'(DEPTH - 1), "R7 drop with pop", 256'(fill_level), 256'(DEPTH - 1));
        // R4: drain with toggling ready
        for (int c = 0; c < 20; c++) begin
            rdy = c[0];
            tick();
        end
        rdy = 1'b1;
        idle(DEPTH);
        chk(buf_empty, "R4 drained", 256'(buf_empty), 256'(1));
        // R7: staging intact after drops
        rdy = 1'b0;
        wr(3'd7, 32'h8000_0042);
        chk(desc_data[64 +: 32] == 32'h0000_1000 && desc_data[0 +: 32] == 32'hA000_0010, "R7 stage intact",
            256'(desc_data[95:0]), 256'({32'h0000_1000, 32'hB000_0020, 32'hA000_0010}));
        // R6: push and pop in one cycle
        rdy = 1'b1;
        wr(3'd7, 32'h8000_0043);
        chk(fill_level == {16'd1, 16'd1}, "R6 push+pop", 256'(fill_level), 256'({16'd1, 16'd1}));
        idle(2);
        chk(overflow, "R7 sticky", 256'(overflow), 256'(1));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule